// File: doc/BRIEF.md
# Register Wakeup and Readiness Tracker

This block follows a small window of instructions that wait on physical source registers. It also keeps a ready scoreboard with one bit per physical register. An instruction is written into a slot along with its source tags and the number of sources it actually uses. Sources whose register is already ready are counted at once. The others wait for a completion broadcast.

A completing instruction presents up to a fixed number of destination tags in one cycle. Every waiting source that names one of those registers is woken. Each entry counts how many of its sources are ready. An entry whose count equals its source count raises its bit in the ready vector. The scheduler then issues from that vector or squashes entries.

Destination tags at or above the physical register count stand for special or control registers. They are ignored. Allocating a register at rename clears its scoreboard bit. A completing memory reference raises a pulse toward the memory dependence logic.

Top module: `reg_wakeup_tracker`

## Requirements
- R1: After reset every ready bit is 0, every scoreboard bit is 1 and the memory wake pulse is 0.
- R2: An insert writes the slot given by `ins_slot_i`, replacing whatever the slot held. It uses sources 0 to `ins_nsrc_i`-1, with `ins_nsrc_i` at most NUM_SRCS. A used source counts as ready at insert if its scoreboard bit is 1 or its tag is at or above NUM_PREGS. An entry with zero sources is ready one cycle after insert.
- R3: A valid, in-range destination tag adds one to the ready count of each waiting source that names it, and that source then stops waiting. A source that names the same register twice is woken twice by one broadcast.
- R4: A ready bit is 1 exactly when its slot is occupied and its ready count equals its source count. The bit changes on the clock edge that follows the causing input.
- R5: Completion sets the scoreboard bit of every valid, in-range destination tag. Up to NUM_DSTS tags are handled in one cycle. Tags are binary physical register numbers.
- R6: A destination tag at or above NUM_PREGS wakes no entry and leaves the scoreboard unchanged. This holds even when its low bits equal a waited-on register.
- R7: An allocation clears the scoreboard bit of an in-range tag. If a completion of the same register happens in the same cycle, the bit stays 1.
- R8: An insert whose source names a register being broadcast in the same cycle counts that source as ready.
- R9: Squash invalidates every slot whose bit in `squash_mask_i` is 1. The scoreboard is not changed. An insert to the same slot in the same cycle takes precedence.
- R10: An issue frees the selected slot only if that slot is ready. An issue of a slot that is not ready is ignored.
- R11: `mem_wake_o` is 1 for one cycle, on the cycle after a completion flagged as a memory reference, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_valid_i | input | 1 | Insert an instruction this cycle |
| ins_slot_i | input | SLOT_W | Slot written by the insert |
| ins_nsrc_i | input | CNT_W | Number of sources used |
| ins_src_tags_i | input | NUM_SRCS*TAG_W | Source tags, source s at bits s*TAG_W |
| alloc_valid_i | input | 1 | Destination register allocation |
| alloc_tag_i | input | TAG_W | Allocated register tag |
| cmp_valid_i | input | 1 | Completion broadcast |
| cmp_is_mem_i | input | 1 | Completing instruction is a memory reference |
| cmp_dst_valid_i | input | NUM_DSTS | Per-destination valid |
| cmp_dst_tags_i | input | NUM_DSTS*TAG_W | Destination tags, slot d at bits d*TAG_W |
| squash_mask_i | input | NUM_ENTRIES | Slots to invalidate |
| issue_valid_i | input | 1 | Issue request |
| issue_slot_i | input | SLOT_W | Slot issued |
| ready_o | output | NUM_ENTRIES | Ready vector |
| scoreboard_o | output | NUM_PREGS | Per-register ready scoreboard |
| mem_wake_o | output | 1 | Memory dependence wake pulse |

## Verification
The bench targets several corner cases.

- An out-of-range tag whose low bits alias a waited-on register. A design that truncates tags would wake that entry early.
- An insert and a broadcast of the same register in the same cycle. A design without the bypass would leave the entry waiting forever.
- An allocation colliding with a completion of the same register. Here a wrong priority would leave the register marked busy.
- Issue of an entry that is not ready. A design that frees the slot unconditionally would lose the instruction.
- Squash. A design that disturbs the scoreboard during squash shows up at the scoreboard port.
- Duplicate source tags in one entry. A design that counts one wakeup per broadcast, rather than per source, never readies that entry.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    SLOT_HOLD = 2'd0,
    SLOT_LOAD = 2'd1,
    SLOT_KILL = 2'd2
  } slot_op_e;
endpackage

// File: rtl/wk_scoreboard.sv
module wk_scoreboard #(
  parameter int NUM_PREGS = 32,
  parameter int NUM_DSTS  = 2,
  parameter int TAG_W     = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_DSTS-1:0]       bc_vld_i,
  input  logic [NUM_DSTS*TAG_W-1:0] bc_tags_i,
  input  logic                      alloc_vld_i,
  input  logic [TAG_W-1:0]          alloc_tag_i,
  output logic [NUM_PREGS-1:0]      sb_o
);
  logic [NUM_PREGS-1:0] sb_q, sb_d;

  always_comb begin
    sb_d = sb_q;
    for (int r = 0; r < NUM_PREGS; r++) begin
      if (alloc_vld_i && alloc_tag_i == TAG_W'(r)) sb_d[r] = 1'b0;
      // completion wins over a colliding allocation
      for (int d = 0; d < NUM_DSTS; d++)
        if (bc_vld_i[d] && bc_tags_i[d*TAG_W +: TAG_W] == TAG_W'(r)) sb_d[r] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sb_q <= '1;
    else         sb_q <= sb_d;

  assign sb_o = sb_q;

  AST_SB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|bc_vld_i) && !(alloc_vld_i && int'(alloc_tag_i) < NUM_PREGS)) |=> $stable(sb_q)); // R6
endmodule

// File: rtl/wk_slot.sv
module wk_slot
  import wk_pkg::*;
#(
  parameter int NUM_SRCS = 2,
  parameter int NUM_DSTS = 2,
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  slot_op_e                  op_i,
  input  logic [CNT_W-1:0]          nsrc_i,
  input  logic [NUM_SRCS*TAG_W-1:0] src_tags_i,
  input  logic [NUM_SRCS-1:0]       src_rdy_i,
  input  logic [NUM_DSTS-1:0]       bc_vld_i,
  input  logic [NUM_DSTS*TAG_W-1:0] bc_tags_i,
  output logic                      ready_o
);
  logic                      valid_q;
  logic [CNT_W-1:0]          nsrc_q, cnt_q;
  logic [NUM_SRCS*TAG_W-1:0] tags_q;
  logic [NUM_SRCS-1:0]       wait_q, hit, used;

  always_comb begin
    for (int s = 0; s < NUM_SRCS; s++) begin
      hit[s]  = 1'b0;
      used[s] = CNT_W'(s) < nsrc_i;
      for (int d = 0; d < NUM_DSTS; d++)
        if (bc_vld_i[d] && bc_tags_i[d*TAG_W +: TAG_W] == tags_q[s*TAG_W +: TAG_W])
          hit[s] = wait_q[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      nsrc_q  <= '0;
      cnt_q   <= '0;
      tags_q  <= '0;
      wait_q  <= '0;
    end else begin
      case (op_i)
        SLOT_LOAD: begin
          valid_q <= 1'b1;
          nsrc_q  <= nsrc_i;
          tags_q  <= src_tags_i;
          wait_q  <= used & ~src_rdy_i;
          cnt_q   <= CNT_W'($countones(used & src_rdy_i));
        end
        SLOT_KILL: begin
          valid_q <= 1'b0;
          wait_q  <= '0;
          cnt_q   <= '0;
        end
        default: if (valid_q) begin
          wait_q <= wait_q & ~hit;
          cnt_q  <= cnt_q + CNT_W'($countones(hit));
        end
      endcase
    end
  end

  assign ready_o = valid_q && (cnt_q == nsrc_q);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> cnt_q <= nsrc_q); // R4
  AST_CNT_WAIT_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (int'(cnt_q) + $countones(wait_q)) == int'(nsrc_q)); // R3
  AST_KILL_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SLOT_KILL) |=> !ready_o); // R9
endmodule

// File: rtl/reg_wakeup_tracker.sv
module reg_wakeup_tracker
  import wk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_SRCS    = 2,
  parameter int NUM_DSTS    = 2,
  parameter int NUM_PREGS   = 32,
  localparam int TAG_W      = $clog2(NUM_PREGS) + 1,
  localparam int SLOT_W     = $clog2(NUM_ENTRIES),
  localparam int CNT_W      = $clog2(NUM_SRCS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ins_valid_i,
  input  logic [SLOT_W-1:0]         ins_slot_i,
  input  logic [CNT_W-1:0]          ins_nsrc_i,
  input  logic [NUM_SRCS*TAG_W-1:0] ins_src_tags_i,
  input  logic                      alloc_valid_i,
  input  logic [TAG_W-1:0]          alloc_tag_i,
  input  logic                      cmp_valid_i,
  input  logic                      cmp_is_mem_i,
  input  logic [NUM_DSTS-1:0]       cmp_dst_valid_i,
  input  logic [NUM_DSTS*TAG_W-1:0] cmp_dst_tags_i,
  input  logic [NUM_ENTRIES-1:0]    squash_mask_i,
  input  logic                      issue_valid_i,
  input  logic [SLOT_W-1:0]         issue_slot_i,
  output logic [NUM_ENTRIES-1:0]    ready_o,
  output logic [NUM_PREGS-1:0]      scoreboard_o,
  output logic                      mem_wake_o
);
  logic [NUM_DSTS-1:0] bc_vld;
  logic [NUM_SRCS-1:0] ins_rdy;
  logic                mem_wake_q;

  // special and control registers never broadcast
  always_comb
    for (int d = 0; d < NUM_DSTS; d++)
      bc_vld[d] = cmp_valid_i && cmp_dst_valid_i[d]
                  && int'(cmp_dst_tags_i[d*TAG_W +: TAG_W]) < NUM_PREGS;

  // insert-time readiness with same-cycle wakeup bypass
  always_comb begin
    for (int s = 0; s < NUM_SRCS; s++) begin
      ins_rdy[s] = int'(ins_src_tags_i[s*TAG_W +: TAG_W]) >= NUM_PREGS;
      for (int r = 0; r < NUM_PREGS; r++)
        if (scoreboard_o[r] && ins_src_tags_i[s*TAG_W +: TAG_W] == TAG_W'(r)) ins_rdy[s] = 1'b1;
      for (int d = 0; d < NUM_DSTS; d++)
        if (bc_vld[d] && ins_src_tags_i[s*TAG_W +: TAG_W] == cmp_dst_tags_i[d*TAG_W +: TAG_W])
          ins_rdy[s] = 1'b1;
    end
  end

  wk_scoreboard #(
    .NUM_PREGS(NUM_PREGS), .NUM_DSTS(NUM_DSTS), .TAG_W(TAG_W)
  ) u_sb (
    .clk_i, .rst_ni,
    .bc_vld_i   (bc_vld),
    .bc_tags_i  (cmp_dst_tags_i),
    .alloc_vld_i(alloc_valid_i),
    .alloc_tag_i(alloc_tag_i),
    .sb_o       (scoreboard_o)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    slot_op_e op;
    always_comb begin
      if (ins_valid_i && ins_slot_i == SLOT_W'(i))
        op = SLOT_LOAD;
      else if (squash_mask_i[i] || (issue_valid_i && issue_slot_i == SLOT_W'(i) && ready_o[i]))
        op = SLOT_KILL;
      else
        op = SLOT_HOLD;
    end

    wk_slot #(
      .NUM_SRCS(NUM_SRCS), .NUM_DSTS(NUM_DSTS), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_slot (
      .clk_i, .rst_ni,
      .op_i      (op),
      .nsrc_i    (ins_nsrc_i),
      .src_tags_i(ins_src_tags_i),
      .src_rdy_i (ins_rdy),
      .bc_vld_i  (bc_vld),
      .bc_tags_i (cmp_dst_tags_i),
      .ready_o   (ready_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mem_wake_q <= 1'b0;
    else         mem_wake_q <= cmp_valid_i && cmp_is_mem_i;

  assign mem_wake_o = mem_wake_q;

  AST_MEM_WAKE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && cmp_is_mem_i) |=> mem_wake_o); // R11
  AST_MEM_WAKE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmp_valid_i && cmp_is_mem_i) |=> !mem_wake_o); // R11
  AST_SQUASH_KEEPS_SB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|squash_mask_i) && !cmp_valid_i && !alloc_valid_i) |=> $stable(scoreboard_o)); // R9
endmodule

// File: tb/sim_reg_wakeup_tracker.sv
module sim_reg_wakeup_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  typedef struct packed {
    logic        iv;  logic [2:0] is; logic [1:0] ns; logic [5:0] s0; logic [5:0] s1;
    logic        av;  logic [5:0] at;
    logic        cv;  logic cm; logic d0v; logic [5:0] d0; logic d1v; logic [5:0] d1;
    logic [7:0]  sq;  logic xv; logic [2:0] xs;
    logic [3:0]  rq;  logic [7:0] er; logic [31:0] es; logic ew;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b1,6'd5,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd7, 8'h00,32'hFFFFFFDF,1'b0}, // R7
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b1,6'd6,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd7, 8'h00,32'hFFFFFF9F,1'b0}, // R7
    '{1'b1,3'd0,2'd2,6'd5,6'd6,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd2, 8'h00,32'hFFFFFF9F,1'b0}, // R2
    '{1'b1,3'd1,2'd1,6'd3,6'd0,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd2, 8'h02,32'hFFFFFF9F,1'b0}, // R2
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b1,1'b1,1'b1,6'd5,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd3, 8'h02,32'hFFFFFFBF,1'b1}, // R3 R11
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b1,1'b0,1'b1,6'd40,1'b1,6'd6,  8'h00,1'b0,3'd0, 4'd5, 8'h03,32'hFFFFFFFF,1'b0}, // R5 R4
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b1,3'd0, 4'd10,8'h02,32'hFFFFFFFF,1'b0}, // R10
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b1,6'd7,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd7, 8'h02,32'hFFFFFF7F,1'b0}, // R7
    '{1'b1,3'd2,2'd2,6'd7,6'd7,  1'b0,6'd0,  1'b1,1'b0,1'b1,6'd7,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd8, 8'h06,32'hFFFFFFFF,1'b0}, // R8
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b1,6'd9,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd7, 8'h06,32'hFFFFFDFF,1'b0}, // R7
    '{1'b1,3'd3,2'd2,6'd9,6'd3,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd2, 8'h06,32'hFFFFFDFF,1'b0}, // R2
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h08,1'b0,3'd0, 4'd9, 8'h06,32'hFFFFFDFF,1'b0}, // R9
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b1,1'b0,1'b1,6'd9,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd9, 8'h06,32'hFFFFFFFF,1'b0}, // R9 squashed slot stays gone
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b1,6'd10, 1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd7, 8'h06,32'hFFFFFBFF,1'b0}, // R7
    '{1'b1,3'd4,2'd1,6'd10,6'd0, 1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd2, 8'h06,32'hFFFFFBFF,1'b0}, // R2
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b1,3'd4, 4'd10,8'h06,32'hFFFFFBFF,1'b0}, // R10 ignored
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b1,1'b0,1'b0,6'd0,1'b1,6'd10,  8'h00,1'b0,3'd0, 4'd10,8'h16,32'hFFFFFFFF,1'b0}, // R10 slot kept
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b1,6'd8,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd7, 8'h16,32'hFFFFFEFF,1'b0}, // R7
    '{1'b1,3'd5,2'd1,6'd8,6'd0,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd2, 8'h16,32'hFFFFFEFF,1'b0}, // R2
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b1,1'b0,1'b1,6'd40,1'b0,6'd0,  8'h00,1'b0,3'd0, 4'd6, 8'h16,32'hFFFFFEFF,1'b0}, // R6 alias of 8
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b1,6'd12, 1'b1,1'b0,1'b1,6'd12,1'b0,6'd0,  8'h00,1'b0,3'd0, 4'd7, 8'h16,32'hFFFFFEFF,1'b0}, // R7 collision
    '{1'b1,3'd6,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd2, 8'h56,32'hFFFFFEFF,1'b0}, // R2 zero sources
    '{1'b1,3'd7,2'd2,6'd45,6'd8, 1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd2, 8'h56,32'hFFFFFEFF,1'b0}, // R2 out-of-range source
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b1,1'b0,1'b1,6'd8,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd3, 8'hF6,32'hFFFFFFFF,1'b0}, // R3 two waiters
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'hFF,1'b0,3'd0, 4'd9, 8'h00,32'hFFFFFFFF,1'b0}, // R9
    '{1'b0,3'd0,2'd0,6'd0,6'd0,  1'b0,6'd0,  1'b0,1'b0,1'b0,6'd0,1'b0,6'd0,   8'h00,1'b0,3'd0, 4'd4, 8'h00,32'hFFFFFFFF,1'b0}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_v, alloc_v, cmp_v, cmp_m, iss_v;
  logic [2:0]  ins_s, iss_s;
  logic [1:0]  ins_n, dv;
  logic [11:0] src_t, dst_t;
  logic [5:0]  alloc_t;
  logic [7:0]  sq;
  logic [7:0]  rdy;
  logic [31:0] sb;
  logic        mw;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_wakeup_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_v), .ins_slot_i(ins_s), .ins_nsrc_i(ins_n), .ins_src_tags_i(src_t),
    .alloc_valid_i(alloc_v), .alloc_tag_i(alloc_t),
    .cmp_valid_i(cmp_v), .cmp_is_mem_i(cmp_m), .cmp_dst_valid_i(dv), .cmp_dst_tags_i(dst_t),
    .squash_mask_i(sq), .issue_valid_i(iss_v), .issue_slot_i(iss_s),
    .ready_o(rdy), .scoreboard_o(sb), .mem_wake_o(mw)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ins_v = 0; ins_s = 0; ins_n = 0; src_t = 0; alloc_v = 0; alloc_t = 0;
    cmp_v = 0; cmp_m = 0; dv = 0; dst_t = 0; sq = 0; iss_v = 0; iss_s = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    #(CLK_PERIOD*2);
    chk("R1", "ready", 32'(rdy), 32'h0);
    chk("R1", "scoreboard", sb, 32'hFFFFFFFF);
    chk("R1", "mem_wake", 32'(mw), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ins_v = TBL[i].iv; ins_s = TBL[i].is; ins_n = TBL[i].ns; src_t = {TBL[i].s1, TBL[i].s0};
      alloc_v = TBL[i].av; alloc_t = TBL[i].at;
      cmp_v = TBL[i].cv; cmp_m = TBL[i].cm; dv = {TBL[i].d1v, TBL[i].d0v}; dst_t = {TBL[i].d1, TBL[i].d0};
      sq = TBL[i].sq; iss_v = TBL[i].xv; iss_s = TBL[i].xs;
      @(posedge clk); #1;
      chk($sformatf("R%0d row%0d", TBL[i].rq, i), "ready", 32'(rdy), 32'(TBL[i].er));
      chk($sformatf("R%0d row%0d", TBL[i].rq, i), "scoreboard", sb, TBL[i].es);
      chk($sformatf("R11 row%0d", i), "mem_wake", 32'(mw), 32'(TBL[i].ew));
    end
    // R11: pulse lasts one cycle only
    @(negedge clk); idle(); cmp_v = 1; cmp_m = 1;
    @(negedge clk); idle();
    chk("R11", "pulse high", 32'(mw), 32'h1);
    @(negedge clk);
    chk("R11", "pulse low", 32'(mw), 32'h0);
    // R1: reset mid-run restores initial state
    ins_v = 1; ins_s = 3'd2; ins_n = 2'd0;
    @(negedge clk); idle(); alloc_v = 1; alloc_t = 6'd1;
    @(negedge clk); idle();
    rst_n = 1'b0; #1;
    chk("R1", "ready after reset", 32'(rdy), 32'h0);
    chk("R1", "scoreboard after reset", sb, 32'hFFFFFFFF);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule